// File: doc/BRIEF.md
# Staged-Read Memory Request Scheduler

This block schedules read and write requests for one memory channel whose banks share a single bidirectional data bus. Reads are accepted into an in-order read queue and writes into a write pool. While the bus faces the read direction, reads go first and writes are held back. Once enough writes accumulate, the bus is turned around and the writes are drained as a burst. A read that would otherwise wait out the drain can have its bank access started early, on a bank the drain is not using. The result of that access is parked in a small staging buffer until the bus faces the read direction again.

The drain aims its writes at a single focus bank for as long as that bank still has queued writes. This keeps the other banks free for early read accesses. Bank access time and the bus turnaround are modelled as fixed cycle counts. The command outputs are abstract strobes: bank, row, column, write and staged flags. The return channel carries the tag of each completed read.

Top module: `staged_read_sched`

## Requirements
- R1: Read responses carry the tags of the accepted reads in exactly the order the reads were accepted, and with no writes pending, every response has `rsp_staged_o` = 0.
- R2: A write command is issued only while `bus_wr_o` = 1. A drain begins once at least WQ_HIGH (6) writes are queued, and it ends with at most WQ_LOW (2) writes still queued.
- R3: Each bus turnaround, in either direction, shows `bus_turn_o` = 1 for exactly TURN_CYC (4) consecutive cycles, with no command and no response in those cycles.
- R4: While `bus_wr_o` = 1, the oldest read may be issued with `cmd_staged_o` = 1 if its bank is idle and its bank is not the drain's focus bank. A staged command never appears outside a drain.
- R5: At most STG_SLOTS (4) staged commands are issued in one drain.
- R6: After the turn back to reads, all staged responses (`rsp_staged_o` = 1) come out before any response to a read issued in the read direction.
- R7: Within a drain, the write commands stay on one bank while writes to that bank remain queued. The focus moves to the bank of the lowest-indexed queued write only when the current focus bank has no queued writes left.
- R8: A read whose bank, row and column equal those of a queued write is not issued until that write has been issued. The presence of such a read also starts a drain, which continues until the matching write has gone out.
- R9: A bank receives no new command within BANK_LAT (6) cycles of its previous command.
- R10: After reset, no command or response is valid, the bus faces reads and is not turning, and both request interfaces are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid_i | input | 1 | Read request valid |
| rd_ready_o | output | 1 | Read queue can accept |
| rd_bank_i | input | 2 | Read bank |
| rd_row_i | input | ROW_W | Read row |
| rd_col_i | input | COL_W | Read column |
| rd_tag_i | input | TAG_W | Read tag, returned with the response |
| wr_valid_i | input | 1 | Write request valid |
| wr_ready_o | output | 1 | Write pool can accept |
| wr_bank_i | input | 2 | Write bank |
| wr_row_i | input | ROW_W | Write row |
| wr_col_i | input | COL_W | Write column |
| cmd_valid_o | output | 1 | A bank command is issued this cycle |
| cmd_write_o | output | 1 | Command is a write |
| cmd_staged_o | output | 1 | Command is an early read access during a drain |
| cmd_bank_o | output | 2 | Command bank |
| cmd_row_o | output | ROW_W | Command row |
| cmd_col_o | output | COL_W | Command column |
| rsp_valid_o | output | 1 | Read data returned on the bus |
| rsp_staged_o | output | 1 | Returned data came from the staging buffer |
| rsp_tag_o | output | TAG_W | Tag of the returned read |
| bus_wr_o | output | 1 | Bus faces the write direction (drain) |
| bus_turn_o | output | 1 | Bus turnaround in progress |

## Verification
A read-only stream with no writes shows that the plain read path keeps order and never uses staging. A burst of writes to one bank, followed by reads to the other three banks, fills the staging buffer. The two reads left over after it is full separate staged returns from ordinary ones and test the four-slot limit. A read that aliases a queued write shows whether the drain runs past its low watermark and holds the read back. Writes alternating between two banks show whether the drain stays on the first bank until that bank is exhausted.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic [1:0] {
        BUS_RD    = 2'd0,
        BUS_TO_WR = 2'd1,
        BUS_WR    = 2'd2,
        BUS_TO_RD = 2'd3
    } bus_state_e;

endpackage

// File: rtl/srs_read_fifo.sv
module srs_read_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic [DW-1:0] head_o,
    output logic          valid_o,
    output logic          ready_o
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [PW:0]   cnt;
    } ptr_t;

    ptr_t          p_d, p_q;
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        p_d = p_q;
        if (push_i) p_d.wr = p_q.wr + PW'(1);
        if (pop_i)  p_d.rd = p_q.rd + PW'(1);
        p_d.cnt = p_q.cnt + (PW+1)'(push_i) - (PW+1)'(pop_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
        if (push_i) mem_q[p_q.wr] <= push_data_i;
    end

    assign head_o  = mem_q[p_q.rd];
    assign valid_o = p_q.cnt != '0;
    assign ready_o = p_q.cnt != (PW+1)'(DEPTH);

    AST_RQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> ready_o); // R1
    AST_RQ_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> valid_o); // R1

endmodule

// File: rtl/srs_stage_buf.sv
module srs_stage_buf #(
    parameter int TAG_W = 4,
    parameter int SLOTS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_i,
    input  logic [TAG_W-1:0]         alloc_tag_i,
    output logic [$clog2(SLOTS)-1:0] alloc_slot_o,
    input  logic                     fill_i,
    input  logic [$clog2(SLOTS)-1:0] fill_slot_i,
    input  logic                     pop_i,
    output logic                     head_ready_o,
    output logic [TAG_W-1:0]         head_tag_o,
    output logic                     empty_o,
    output logic                     full_o
);
    localparam int SW = $clog2(SLOTS);

    typedef struct packed {
        logic [SLOTS-1:0] rdy;
        logic [SW-1:0]    hd;
        logic [SW-1:0]    tl;
        logic [SW:0]      cnt;
    } sb_t;

    sb_t              s_d, s_q;
    logic [TAG_W-1:0] tag_q [SLOTS];

    always_comb begin
        s_d = s_q;
        if (alloc_i) begin
            s_d.rdy[s_q.tl] = 1'b0;
            s_d.tl          = s_q.tl + SW'(1);
        end
        if (fill_i) s_d.rdy[fill_slot_i] = 1'b1;
        if (pop_i)  s_d.hd = s_q.hd + SW'(1);
        s_d.cnt = s_q.cnt + (SW+1)'(alloc_i) - (SW+1)'(pop_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
        if (alloc_i) tag_q[s_q.tl] <= alloc_tag_i;
    end

    assign alloc_slot_o = s_q.tl;
    assign empty_o      = s_q.cnt == '0;
    assign full_o       = s_q.cnt == (SW+1)'(SLOTS);
    assign head_ready_o = !empty_o && s_q.rdy[s_q.hd];
    assign head_tag_o   = tag_q[s_q.hd];

    AST_STAGE_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> !full_o); // R5
    AST_STAGE_POP_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> head_ready_o); // R6

endmodule

// File: rtl/srs_bank_timer.sv
module srs_bank_timer #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_LAT  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] issue_i,
    output logic [NUM_BANKS-1:0] busy_o
);
    localparam int CW = $clog2(BANK_LAT + 1);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [CW-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (issue_i[b])         cnt_d = CW'(BANK_LAT);
            else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign busy_o[b] = cnt_q != '0;

        AST_BANK_IDLE_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
            issue_i[b] |-> !busy_o[b]); // R9
    end

    AST_ONE_BANK_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_i)); // R9

endmodule

// File: rtl/staged_read_sched.sv
module staged_read_sched
    import srs_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 4,
    parameter int COL_W     = 3,
    parameter int TAG_W     = 4,
    parameter int RQ_DEPTH  = 8,
    parameter int WQ_DEPTH  = 8,
    parameter int STG_SLOTS = 4,
    parameter int BANK_LAT  = 6,
    parameter int TURN_CYC  = 4,
    parameter int WQ_HIGH   = 6,
    parameter int WQ_LOW    = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_valid_i,
    output logic                         rd_ready_o,
    input  logic [$clog2(NUM_BANKS)-1:0] rd_bank_i,
    input  logic [ROW_W-1:0]             rd_row_i,
    input  logic [COL_W-1:0]             rd_col_i,
    input  logic [TAG_W-1:0]             rd_tag_i,
    input  logic                         wr_valid_i,
    output logic                         wr_ready_o,
    input  logic [$clog2(NUM_BANKS)-1:0] wr_bank_i,
    input  logic [ROW_W-1:0]             wr_row_i,
    input  logic [COL_W-1:0]             wr_col_i,
    output logic                         cmd_valid_o,
    output logic                         cmd_write_o,
    output logic                         cmd_staged_o,
    output logic [$clog2(NUM_BANKS)-1:0] cmd_bank_o,
    output logic [ROW_W-1:0]             cmd_row_o,
    output logic [COL_W-1:0]             cmd_col_o,
    output logic                         rsp_valid_o,
    output logic                         rsp_staged_o,
    output logic [TAG_W-1:0]             rsp_tag_o,
    output logic                         bus_wr_o,
    output logic                         bus_turn_o
);
    localparam int BW  = $clog2(NUM_BANKS);
    localparam int AW  = BW + ROW_W + COL_W;
    localparam int RDW = AW + TAG_W;
    localparam int WQW = $clog2(WQ_DEPTH);
    localparam int WCW = $clog2(WQ_DEPTH + 1);
    localparam int SW  = $clog2(STG_SLOTS);
    localparam int TCW = $clog2(TURN_CYC) + 1;
    localparam logic [WCW-1:0] HI_LVL = WCW'(WQ_HIGH);
    localparam logic [WCW-1:0] LO_LVL = WCW'(WQ_LOW);
    localparam logic [WCW-1:0] WQ_MAX = WCW'(WQ_DEPTH);
    localparam logic [TCW-1:0] TURN_LD = TCW'(TURN_CYC - 1);

    typedef struct packed {
        logic          v;
        logic          staged;
        logic [TAG_W-1:0] tag;
        logic [SW-1:0] slot;
    } pipe_t;

    typedef struct packed {
        bus_state_e        st;
        logic [TCW-1:0]    tcnt;
        logic [BW-1:0]     focus;
        logic [WQ_DEPTH-1:0] wv;
        logic              rsp_v;
        logic              rsp_staged;
        logic [TAG_W-1:0]  rsp_tag;
    } ctl_t;

    ctl_t        c_q, c_d;
    logic [AW-1:0] wa_q [WQ_DEPTH];
    logic [AW-1:0] wa_d [WQ_DEPTH];
    pipe_t       pipe_q [BANK_LAT];
    pipe_t       pipe_d [BANK_LAT];

    // read queue, staging buffer and bank timers
    logic [RDW-1:0] rq_head;
    logic           rq_valid, rq_pop;
    logic           stg_alloc, stg_fill, stg_pop, stg_head_ready, stg_empty, stg_full;
    logic [SW-1:0]  stg_alloc_slot, stg_fill_slot;
    logic [TAG_W-1:0] stg_head_tag;
    logic [NUM_BANKS-1:0] bank_issue, bank_busy;

    srs_read_fifo #(.DW(RDW), .DEPTH(RQ_DEPTH)) i_rq (
        .clk, .rst_n,
        .push_i      (rd_valid_i && rd_ready_o),
        .push_data_i ({rd_bank_i, rd_row_i, rd_col_i, rd_tag_i}),
        .pop_i       (rq_pop),
        .head_o      (rq_head),
        .valid_o     (rq_valid),
        .ready_o     (rd_ready_o)
    );

    srs_stage_buf #(.TAG_W(TAG_W), .SLOTS(STG_SLOTS)) i_stg (
        .clk, .rst_n,
        .alloc_i      (stg_alloc),
        .alloc_tag_i  (rq_head[TAG_W-1:0]),
        .alloc_slot_o (stg_alloc_slot),
        .fill_i       (stg_fill),
        .fill_slot_i  (stg_fill_slot),
        .pop_i        (stg_pop),
        .head_ready_o (stg_head_ready),
        .head_tag_o   (stg_head_tag),
        .empty_o      (stg_empty),
        .full_o       (stg_full)
    );

    srs_bank_timer #(.NUM_BANKS(NUM_BANKS), .BANK_LAT(BANK_LAT)) i_banks (
        .clk, .rst_n,
        .issue_i (bank_issue),
        .busy_o  (bank_busy)
    );

    // views of the current state
    logic [AW-1:0]  head_addr;
    logic [BW-1:0]  head_bank, eff_bank, first_bank;
    logic [WCW-1:0] wcnt;
    logic [WQW-1:0] free_idx, pick_idx;
    logic           hazard, has_focus, pipe_idle;

    assign head_addr = rq_head[RDW-1:TAG_W];
    assign head_bank = head_addr[AW-1 -: BW];

    always_comb begin
        wcnt       = '0;
        hazard     = 1'b0;
        has_focus  = 1'b0;
        first_bank = '0;
        free_idx   = '0;
        pick_idx   = '0;
        pipe_idle  = 1'b1;
        for (int i = WQ_DEPTH - 1; i >= 0; i--) begin
            if (c_q.wv[i]) begin
                wcnt       = wcnt + WCW'(1);
                first_bank = wa_q[i][AW-1 -: BW];
                if (rq_valid && wa_q[i] == head_addr)  hazard    = 1'b1;
                if (wa_q[i][AW-1 -: BW] == c_q.focus)  has_focus = 1'b1;
            end else begin
                free_idx = WQW'(i);
            end
        end
        eff_bank = has_focus ? c_q.focus : first_bank;
        for (int i = WQ_DEPTH - 1; i >= 0; i--) begin
            if (c_q.wv[i] && wa_q[i][AW-1 -: BW] == eff_bank) pick_idx = WQW'(i);
        end
        for (int i = 0; i < BANK_LAT; i++) begin
            if (pipe_q[i].v) pipe_idle = 1'b0;
        end
    end

    assign wr_ready_o = wcnt < WQ_MAX;

    always_comb begin
        c_d  = c_q;
        wa_d = wa_q;
        rq_pop = 1'b0;  stg_alloc = 1'b0;  stg_pop = 1'b0;
        cmd_valid_o = 1'b0;  cmd_write_o = 1'b0;  cmd_staged_o = 1'b0;
        {cmd_bank_o, cmd_row_o, cmd_col_o} = head_addr;
        c_d.rsp_v      = 1'b0;
        c_d.rsp_staged = 1'b0;

        pipe_d[0] = '0;
        for (int i = 1; i < BANK_LAT; i++) pipe_d[i] = pipe_q[i-1];

        stg_fill      = pipe_q[BANK_LAT-1].v && pipe_q[BANK_LAT-1].staged;
        stg_fill_slot = pipe_q[BANK_LAT-1].slot;
        if (pipe_q[BANK_LAT-1].v && !pipe_q[BANK_LAT-1].staged) begin
            c_d.rsp_v   = 1'b1;
            c_d.rsp_tag = pipe_q[BANK_LAT-1].tag;
        end

        if (wr_valid_i && wr_ready_o) begin
            c_d.wv[free_idx] = 1'b1;
            wa_d[free_idx]   = {wr_bank_i, wr_row_i, wr_col_i};
        end

        unique case (c_q.st)
            BUS_RD: begin
                if (!stg_empty) begin
                    if (stg_head_ready) begin
                        stg_pop        = 1'b1;
                        c_d.rsp_v      = 1'b1;
                        c_d.rsp_staged = 1'b1;
                        c_d.rsp_tag    = stg_head_tag;
                    end
                end else if (wcnt >= HI_LVL || hazard) begin
                    if (pipe_idle) begin
                        c_d.st   = BUS_TO_WR;
                        c_d.tcnt = TURN_LD;
                    end
                end else if (rq_valid && !bank_busy[head_bank]) begin
                    cmd_valid_o = 1'b1;
                    rq_pop      = 1'b1;
                    pipe_d[0]   = '{v: 1'b1, staged: 1'b0, tag: rq_head[TAG_W-1:0], slot: '0};
                end
            end
            BUS_WR: begin
                if (wcnt <= LO_LVL && !hazard) begin
                    c_d.st   = BUS_TO_RD;
                    c_d.tcnt = TURN_LD;
                end else begin
                    c_d.focus = eff_bank;
                    if (!bank_busy[eff_bank]) begin
                        cmd_valid_o = 1'b1;
                        cmd_write_o = 1'b1;
                        {cmd_bank_o, cmd_row_o, cmd_col_o} = wa_q[pick_idx];
                        c_d.wv[pick_idx] = 1'b0;
                    end else if (rq_valid && !hazard && !stg_full &&
                                 !bank_busy[head_bank] && head_bank != eff_bank) begin
                        cmd_valid_o  = 1'b1;
                        cmd_staged_o = 1'b1;
                        rq_pop       = 1'b1;
                        stg_alloc    = 1'b1;
                        pipe_d[0]    = '{v: 1'b1, staged: 1'b1, tag: rq_head[TAG_W-1:0],
                                         slot: stg_alloc_slot};
                    end
                end
            end
            default: begin
                if (c_q.tcnt == '0) c_d.st = (c_q.st == BUS_TO_WR) ? BUS_WR : BUS_RD;
                else                c_d.tcnt = c_q.tcnt - TCW'(1);
            end
        endcase

        bank_issue = cmd_valid_o ? (NUM_BANKS'(1) << cmd_bank_o) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '{st: BUS_RD, default: '0};
            pipe_q <= '{default: '0};
        end else begin
            c_q    <= c_d;
            pipe_q <= pipe_d;
        end
        wa_q <= wa_d;
    end

    assign rsp_valid_o  = c_q.rsp_v;
    assign rsp_staged_o = c_q.rsp_staged;
    assign rsp_tag_o    = c_q.rsp_tag;
    assign bus_wr_o     = c_q.st == BUS_WR;
    assign bus_turn_o   = c_q.st == BUS_TO_WR || c_q.st == BUS_TO_RD;

    AST_WRITE_ON_WRITE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_write_o) |-> bus_wr_o); // R2
    AST_TURN_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_turn_o |-> !cmd_valid_o); // R3
    AST_TURN_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_turn_o |-> !rsp_valid_o); // R3
    AST_TURN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_turn_o) |=> bus_turn_o); // R3
    AST_STAGE_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_staged_o |-> (bus_wr_o && !cmd_write_o)); // R4
    AST_STAGED_BEFORE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q[BANK_LAT-1].v && !pipe_q[BANK_LAT-1].staged) |-> stg_empty); // R6

endmodule

// File: tb/test_staged_read_sched.sv
module test_staged_read_sched;
    localparam int NB = 4, ROW_W = 4, COL_W = 3, TAG_W = 4;
    localparam int LAT = 6, TURN = 4, HI = 6, LO = 2, SLOTS = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rd_valid_i = 1'b0, wr_valid_i = 1'b0;
    logic [1:0] rd_bank_i = '0, wr_bank_i = '0;
    logic [ROW_W-1:0] rd_row_i = '0, wr_row_i = '0;
    logic [COL_W-1:0] rd_col_i = '0, wr_col_i = '0;
    logic [TAG_W-1:0] rd_tag_i = '0;
    logic rd_ready_o, wr_ready_o, cmd_valid_o, cmd_write_o, cmd_staged_o;
    logic [1:0] cmd_bank_o;
    logic [ROW_W-1:0] cmd_row_o;
    logic [COL_W-1:0] cmd_col_o;
    logic rsp_valid_o, rsp_staged_o, bus_wr_o, bus_turn_o;
    logic [TAG_W-1:0] rsp_tag_o;

    staged_read_sched i_staged_read_sched (.*);

    always #10 clk = ~clk;

    int n_checks = 0, n_err = 0;
    int exp_tag[$];
    int exp_stg[$];       // 0, 1, or 2 for either
    int pend_w[$];        // addresses of accepted, not yet issued writes
    bit chk_hi = 1'b1;
    bit done = 1'b0;

    function automatic int addr_of(input int b, input int r, input int c);
        return (b << (ROW_W + COL_W)) | (r << COL_W) | c;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_wr(input int b, input int r, input int c);
        @(negedge clk);
        wr_valid_i = 1'b1; wr_bank_i = 2'(b); wr_row_i = ROW_W'(r); wr_col_i = COL_W'(c);
        while (!wr_ready_o) @(negedge clk);
        @(posedge clk); #1;
        wr_valid_i = 1'b0;
        pend_w.push_back(addr_of(b, r, c));
    endtask

    task automatic send_rd(input int b, input int r, input int c, input int tag, input int stg);
        @(negedge clk);
        rd_valid_i = 1'b1; rd_bank_i = 2'(b); rd_row_i = ROW_W'(r); rd_col_i = COL_W'(c);
        rd_tag_i = TAG_W'(tag);
        while (!rd_ready_o) @(negedge clk);
        @(posedge clk); #1;
        rd_valid_i = 1'b0;
        exp_tag.push_back(tag);
        exp_stg.push_back(stg);
    endtask

    task automatic wait_drained();
        for (int k = 0; k < 400 && exp_tag.size() != 0; k++) @(negedge clk);
        chk(exp_tag.size() == 0, "R1 all reads returned", exp_tag.size(), 0);
        repeat (10) @(negedge clk);
    endtask

    // monitor
    int  cyc = 0, turn_len = 0, drain_stg = 0, last_cmd[NB];
    bit  prev_turn = 0, prev_wr = 0, seen_plain = 0, foc_v = 0;
    int  foc_bank = 0;

    initial for (int b = 0; b < NB; b++) last_cmd[b] = -100;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int a;
            cyc++;
            a = addr_of(cmd_bank_o, cmd_row_o, cmd_col_o);
            if (bus_turn_o) begin
                chk(!cmd_valid_o && !rsp_valid_o, "R3 quiet turnaround", cmd_valid_o | rsp_valid_o, 0);
                if (!prev_turn) begin
                    if (prev_wr) begin
                        chk(pend_w.size() <= LO, "R2 drain end level", pend_w.size(), LO);
                        chk(drain_stg <= SLOTS, "R5 staged per drain", drain_stg, SLOTS);
                        seen_plain = 0;
                    end else begin
                        if (chk_hi) chk(pend_w.size() >= HI, "R2 drain start level", pend_w.size(), HI);
                        drain_stg = 0;
                        foc_v = 0;
                    end
                end
                turn_len++;
            end else if (prev_turn) begin
                chk(turn_len == TURN, "R3 turnaround length", turn_len, TURN);
                turn_len = 0;
            end
            if (cmd_valid_o) begin
                chk(cyc - last_cmd[cmd_bank_o] >= LAT, "R9 bank spacing",
                    cyc - last_cmd[cmd_bank_o], LAT);
                last_cmd[cmd_bank_o] = cyc;
                if (cmd_write_o) begin
                    chk(bus_wr_o, "R2 write on write bus", bus_wr_o, 1);
                    if (foc_v && cmd_bank_o != foc_bank) begin
                        int left = 0;
                        foreach (pend_w[i]) if ((pend_w[i] >> (ROW_W + COL_W)) == foc_bank) left++;
                        chk(left == 0, "R7 focus bank kept", left, 0);
                    end
                    foc_v = 1; foc_bank = cmd_bank_o;
                    foreach (pend_w[i]) if (pend_w[i] == a) begin pend_w.delete(i); break; end
                end else begin
                    int hit = 0;
                    foreach (pend_w[i]) if (pend_w[i] == a) hit++;
                    chk(hit == 0, "R8 read after queued write", hit, 0);
                    if (cmd_staged_o) begin
                        chk(bus_wr_o, "R4 staged only in drain", bus_wr_o, 1);
                        drain_stg++;
                    end
                end
            end
            if (rsp_valid_o) begin
                if (exp_tag.size() == 0) begin
                    chk(0, "R1 unexpected response", rsp_tag_o, -1);
                end else begin
                    int et, es;
                    et = exp_tag.pop_front();
                    es = exp_stg.pop_front();
                    chk(rsp_tag_o == et, "R1 response order", rsp_tag_o, et);
                    if (es != 2) chk(rsp_staged_o == es, "R4 staged flag", rsp_staged_o, es);
                end
                if (rsp_staged_o)
                    chk(!seen_plain, "R6 staged before new reads", seen_plain, 0);
                else
                    seen_plain = 1;
            end
            prev_turn = bus_turn_o;
            prev_wr   = bus_wr_o;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!cmd_valid_o && !rsp_valid_o, "R10 idle outputs", cmd_valid_o | rsp_valid_o, 0);
        chk(!bus_wr_o && !bus_turn_o, "R10 bus faces reads", bus_wr_o | bus_turn_o, 0);
        chk(rd_ready_o && wr_ready_o, "R10 ready", rd_ready_o & wr_ready_o, 1);

        // R1: plain reads, no writes
        for (int i = 0; i < 5; i++) send_rd(i % NB, i, 1, i, 0);
        wait_drained();

        // R4 R5 R6: drain on bank 0, reads to other banks get staged up to 4
        for (int i = 0; i < 6; i++) send_wr(0, i, 0);
        send_rd(1, 1, 2, 8, 1);
        send_rd(2, 1, 2, 9, 1);
        send_rd(3, 1, 2, 10, 1);
        send_rd(1, 2, 2, 11, 1);
        send_rd(2, 2, 2, 12, 0);
        send_rd(3, 2, 2, 13, 0);
        wait_drained();

        // R8: read aliasing a queued write (bank 0 row 5 col 0)
        chk_hi = 1'b0;
        send_rd(0, 5, 0, 14, 0);
        wait_drained();
        chk(pend_w.size() == 0, "R8 aliased write issued", pend_w.size(), 0);
        chk_hi = 1'b1;

        // R7: writes alternating between banks 2 and 3
        for (int i = 0; i < 6; i++) send_wr(2 + (i % 2), i, 3);
        repeat (60) @(negedge clk);
        chk(pend_w.size() == LO, "R2 drain stops at low level", pend_w.size(), LO);

        // R1: reads after the drain, none staged
        for (int i = 0; i < 3; i++) send_rd(i, 7, 7, i, 0);
        wait_drained();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule